// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides when a small 8-bit microcontroller runs and when it sleeps. Firmware writes a power-control register, and setting bit 1 of that register puts the part into full power-down. While asleep, the core clock and the PLL clock are gated off. The oscillator either keeps running or stops, depending on an oscillator-stop bit held in a second, PLL-control register. Peripheral enables are dropped and the port output register freezes. The DAC output enable is released so the pin goes three-state. The address-latch and program-store strobes toward the external bus are held low.

Three things bring the part back. The first is the external reset, which restores every register to its default. The second is an enabled interrupt request. The third is an expiry of the time-interval counter, which counts only while the oscillator is kept alive. The last two clear the power-down bit and leave every other register as it was. They then hold the core clock off for a programmable lock wait, so that the PLL settles before the core sees any edge. The core and PLL clocks are gated through enables that change only while the reference clock is low, so no gated clock carries a shortened pulse.

Top module: `pdn_ctrl`

## Requirements
- R1: A write to the power-control register with bit 1 set, made in normal mode, stores the written byte and puts the block in power-down (pd_active high) from the next cycle.
- R2: In power-down, core_clk shows no rising edge and pll_en is low.
- R3: In power-down, osc_en is low when bit 7 of the PLL-control register is 1, and high when that bit is 0; outside power-down osc_en is high.
- R4: In power-down, tic_run is high only when tic_en is high and the oscillator is kept; periph_en is all zeros whenever pd_active is high.
- R5: port_q keeps its value while pd_active is high; port writes made then are ignored.
- R6: dac_oe, ale and psen are low whenever pd_active is high, whatever their requests from the core.
- R7: rst (synchronous, active high) returns the block to normal mode with power-control 0x00, PLL-control 0x00 and port_q all ones, also when applied in power-down.
- R8: An irq in power-down leads to the lock wait on the next edge; bit 1 of the power-control register is cleared, and its other bits and port_q are kept.
- R9: A time-interval counter expiry wakes the block from power-down only if the oscillator is kept; with bit 7 of the PLL-control register set, the block stays in power-down.
- R10: After the edge that takes a wake request, the block spends exactly lock_cycles+1 cycles in the lock wait, with the core clock gated. pd_active therefore falls after the (lock_cycles+2)-th edge, counting the wake edge as the first. No high pulse of core_clk is shorter than half a reference period.
- R11: In normal mode periph_en equals periph_req, and dac_oe, ale and psen follow their requests.
- R12: While it runs, the time-interval counter pulses tic_irq once every tic_limit+1 cycles; tic_en low clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock from the oscillator |
| rst | input | 1 | Synchronous active-high reset from the external reset pin |
| pwr_wr | input | 1 | Write strobe for the power-control register |
| pwr_wdata | input | 8 | Power-control write data; bit 1 requests power-down |
| pll_wr | input | 1 | Write strobe for the PLL-control register |
| pll_wdata | input | 8 | PLL-control write data; bit 7 stops the oscillator in power-down |
| port_wr | input | 1 | Write strobe for the port output register |
| port_wdata | input | PW | Port output write data |
| irq | input | 1 | Enabled interrupt request used as a wake source |
| tic_en | input | 1 | Time-interval counter enable |
| tic_limit | input | TW | Counter terminal value; period is tic_limit+1 cycles |
| lock_cycles | input | LW | PLL lock wait length after a wake |
| periph_req | input | NP | Peripheral enables requested by firmware |
| dac_oe_req | input | 1 | DAC output enable requested by firmware |
| ale_core | input | 1 | Address-latch strobe from the core |
| psen_core | input | 1 | Program-store strobe from the core |
| core_clk | output | 1 | Gated core clock |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_clk | output | 1 | Gated PLL clock |
| pll_en | output | 1 | PLL clock gate enable |
| osc_en | output | 1 | Oscillator run enable |
| tic_run | output | 1 | Time-interval counter is counting |
| tic_irq | output | 1 | Time-interval counter expiry pulse |
| periph_en | output | NP | Peripheral enables after power gating |
| dac_oe | output | 1 | DAC output enable (low means three-state) |
| ale | output | 1 | Address-latch strobe to the pins |
| psen | output | 1 | Program-store strobe to the pins |
| port_q | output | PW | Port output register |
| pcon_q | output | 8 | Power-control register contents |
| pllcon_q | output | 8 | PLL-control register contents |
| pd_active | output | 1 | High in power-down and during the lock wait |

## Verification
The bench builds the block with a 4-bit lock wait, a 4-bit time-interval counter, four peripheral enables and an 8-bit port. This configuration lets it enter and leave power-down once for every lock wait from 0 to 15. Each pass alternates the oscillator-stop bit and writes a different pattern into the upper power-control bits, and the bench measures the exact wake latency against lock_cycles+2 edges. The bench also sweeps terminal values 0 to 7 of the time-interval counter and compares each period with tic_limit+1. It exercises timer wakes with the oscillator kept and with it stopped, and it times every high pulse of the gated core clock.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PDN  = 2'd1,
    ST_LOCK = 2'd2
  } pd_state_e;

  localparam int REG_W      = 8;
  localparam int PD_BIT     = 1;   // power-down request bit in power-control
  localparam int OSC_PD_BIT = 7;   // oscillator stop bit in PLL-control
  localparam int NGATE      = 2;   // index 0: core clock, index 1: PLL clock
endpackage

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enter,
  input  logic          wake,
  input  logic [LW-1:0] lock_cycles,
  output pd_state_e     st,
  output logic [LW-1:0] lock_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RUN;
      lock_cnt <= '0;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (enter) st <= ST_PDN;
        end
        ST_PDN: begin
          if (wake) begin
            st       <= ST_LOCK;
            lock_cnt <= lock_cycles;
          end
        end
        ST_LOCK: begin
          if (lock_cnt == '0) st <= ST_RUN;
          else                lock_cnt <= lock_cnt - 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pdn_tic.sv
module pdn_tic #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          irq
);
  logic [TW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (run) begin
      irq <= at_end;
      cnt <= at_end ? '0 : cnt + 1'b1;
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pdn_clkgate.sv
module pdn_clkgate #(
  parameter int NG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NG-1:0] en_d,
  output logic [NG-1:0] en_q,
  output logic [NG-1:0] gclk
);
  // Enables move only on the falling edge, while clk is low.
  always_ff @(negedge clk) begin
    if (rst) en_q <= '1;
    else     en_q <= en_d;
  end

  for (genvar g = 0; g < NG; g++) begin : g_gate
    assign gclk[g] = clk & en_q[g];
  end
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int              NP       = 4,
  parameter int              PW       = 8,
  parameter int              LW       = 4,
  parameter int              TW       = 4,
  parameter logic [PW-1:0]   PORT_RST = '1,
  parameter logic [REG_W-1:0] PLL_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_wr,
  input  logic [REG_W-1:0] pwr_wdata,
  input  logic             pll_wr,
  input  logic [REG_W-1:0] pll_wdata,
  input  logic             port_wr,
  input  logic [PW-1:0]    port_wdata,
  input  logic             irq,
  input  logic             tic_en,
  input  logic [TW-1:0]    tic_limit,
  input  logic [LW-1:0]    lock_cycles,
  input  logic [NP-1:0]    periph_req,
  input  logic             dac_oe_req,
  input  logic             ale_core,
  input  logic             psen_core,
  output logic             core_clk,
  output logic             core_clk_en,
  output logic             pll_clk,
  output logic             pll_en,
  output logic             osc_en,
  output logic             tic_run,
  output logic             tic_irq,
  output logic [NP-1:0]    periph_en,
  output logic             dac_oe,
  output logic             ale,
  output logic             psen,
  output logic [PW-1:0]    port_q,
  output logic [REG_W-1:0] pcon_q,
  output logic [REG_W-1:0] pllcon_q,
  output logic             pd_active
);
  pd_state_e     st;
  logic [LW-1:0] lock_cnt;
  logic          run, in_pdn, osc_stop, enter, wake;
  logic [NGATE-1:0] gate_d, gate_q, gate_clk;

  assign run      = (st == ST_RUN);
  assign in_pdn   = (st == ST_PDN);
  assign osc_stop = pllcon_q[OSC_PD_BIT];
  assign enter    = run && pwr_wr && pwr_wdata[PD_BIT];
  assign wake     = in_pdn && (irq || (tic_irq && !osc_stop));

  pdn_fsm #(.LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .enter(enter), .wake(wake),
    .lock_cycles(lock_cycles), .st(st), .lock_cnt(lock_cnt)
  );

  // Register file: writable only while the core is clocked.
  always_ff @(posedge clk) begin
    if (rst) begin
      pcon_q   <= '0;
      pllcon_q <= PLL_RST;
      port_q   <= PORT_RST;
    end else begin
      if (run && pwr_wr)   pcon_q <= pwr_wdata;
      else if (wake)       pcon_q[PD_BIT] <= 1'b0;
      if (run && pll_wr)   pllcon_q <= pll_wdata;
      if (run && port_wr)  port_q <= port_wdata;
    end
  end

  assign osc_en  = !(in_pdn && osc_stop);
  assign tic_run = tic_en && osc_en;

  pdn_tic #(.TW(TW)) u_tic (
    .clk(clk), .rst(rst), .en(tic_en), .run(osc_en),
    .limit(tic_limit), .irq(tic_irq)
  );

  assign gate_d[0] = run;
  assign gate_d[1] = !in_pdn;

  pdn_clkgate #(.NG(NGATE)) u_gate (
    .clk(clk), .rst(rst), .en_d(gate_d), .en_q(gate_q), .gclk(gate_clk)
  );

  assign core_clk    = gate_clk[0];
  assign core_clk_en = gate_q[0];
  assign pll_clk     = gate_clk[1];
  assign pll_en      = gate_q[1];

  assign periph_en = run ? periph_req : '0;
  assign dac_oe    = run && dac_oe_req;
  assign ale       = run && ale_core;
  assign psen      = run && psen_core;
  assign pd_active = !run;
endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk
  import pdn_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst,
  input pd_state_e        st,
  input logic             pwr_wr,
  input logic [REG_W-1:0] pwr_wdata,
  input logic             irq,
  input logic             core_clk_en,
  input logic             pll_en,
  input logic             tic_run,
  input logic [REG_W-1:0] pllcon_q,
  input logic [REG_W-1:0] pcon_q,
  input logic [PW-1:0]    port_q,
  input logic [NP-1:0]    periph_en,
  input logic             dac_oe,
  input logic             ale,
  input logic             psen
);
  assert_enter_pd_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && pwr_wr && pwr_wdata[PD_BIT]) |=> (st == ST_PDN && pcon_q[PD_BIT]));

  assert_clocks_off_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDN) |-> (!core_clk_en && !pll_en));

  assert_tic_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDN && pllcon_q[OSC_PD_BIT]) |-> !tic_run);

  assert_port_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RUN) |=> $stable(port_q));

  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RUN) |-> (!dac_oe && !ale && !psen && periph_en == '0));

  assert_irq_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDN && irq) |=> (st == ST_LOCK && !pcon_q[PD_BIT]));

  assert_lock_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCK) |-> !core_clk_en);
endmodule

bind pdn_ctrl pdn_ctrl_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .st(st), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
  .irq(irq), .core_clk_en(core_clk_en), .pll_en(pll_en), .tic_run(tic_run),
  .pllcon_q(pllcon_q), .pcon_q(pcon_q), .port_q(port_q),
  .periph_en(periph_en), .dac_oe(dac_oe), .ale(ale), .psen(psen)
);

// File: tb/tb_pdn_ctrl.sv
`timescale 1ns/1ps
module tb_pdn_ctrl;
  localparam int NP = 4, PW = 8, LW = 4, TW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic pwr_wr = 0, pll_wr = 0, port_wr = 0, irq = 0, tic_en = 0;
  logic [7:0] pwr_wdata = '0, pll_wdata = '0;
  logic [PW-1:0] port_wdata = '0;
  logic [TW-1:0] tic_limit = '0;
  logic [LW-1:0] lock_cycles = '0;
  logic [NP-1:0] periph_req = '0;
  logic dac_oe_req = 0, ale_core = 0, psen_core = 0;
  logic core_clk, core_clk_en, pll_clk, pll_en, osc_en, tic_run, tic_irq;
  logic [NP-1:0] periph_en;
  logic dac_oe, ale, psen, pd_active;
  logic [PW-1:0] port_q;
  logic [7:0] pcon_q, pllcon_q;

  int checks = 0, errors = 0, core_edges = 0, short_pulses = 0;
  bit done = 0;
  realtime t_rise = 0.0;

  always #2 clk = ~clk;

  pdn_ctrl #(.NP(NP), .PW(PW), .LW(LW), .TW(TW)) dut (
    .clk(clk), .rst(rst), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
    .pll_wr(pll_wr), .pll_wdata(pll_wdata), .port_wr(port_wr),
    .port_wdata(port_wdata), .irq(irq), .tic_en(tic_en), .tic_limit(tic_limit),
    .lock_cycles(lock_cycles), .periph_req(periph_req), .dac_oe_req(dac_oe_req),
    .ale_core(ale_core), .psen_core(psen_core), .core_clk(core_clk),
    .core_clk_en(core_clk_en), .pll_clk(pll_clk), .pll_en(pll_en),
    .osc_en(osc_en), .tic_run(tic_run), .tic_irq(tic_irq),
    .periph_en(periph_en), .dac_oe(dac_oe), .ale(ale), .psen(psen),
    .port_q(port_q), .pcon_q(pcon_q), .pllcon_q(pllcon_q), .pd_active(pd_active)
  );

  // R10: time every high pulse of the gated core clock
  always @(posedge core_clk) begin
    core_edges++;
    t_rise = $realtime;
  end
  always @(negedge core_clk) if ($realtime - t_rise < 1.999) short_pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic write_pll(input logic [7:0] d);
    @(negedge clk); pll_wr = 1; pll_wdata = d;
    @(negedge clk); pll_wr = 0;
  endtask

  task automatic enter_pd(input logic [7:0] d);
    @(negedge clk); pwr_wr = 1; pwr_wdata = d;
    @(negedge clk); pwr_wr = 0;
    chk("R1 pd_active", int'(pd_active), 1);
    chk("R1 pcon", int'(pcon_q), int'(d));
  endtask

  task automatic wait_awake(input int maxc, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
    end while (pd_active && n < maxc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int n, e0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R7 reset state
    chk("R7 pd_active", int'(pd_active), 0);
    chk("R7 pcon", int'(pcon_q), 0);
    chk("R7 pllcon", int'(pllcon_q), 0);
    chk("R7 port", int'(port_q), 255);
    @(negedge clk); port_wr = 1; port_wdata = 8'hA5;
    @(negedge clk); port_wr = 0;
    chk("R5 port write in run", int'(port_q), 8'hA5);
    periph_req = 4'b1011; dac_oe_req = 1; ale_core = 1; psen_core = 1;
    #1;
    chk("R11 periph_en", int'(periph_en), 4'b1011);
    chk("R11 ale/psen/dac", int'({ale, psen, dac_oe}), 7);
    chk("R3 osc_en run", int'(osc_en), 1);

    for (int L = 0; L < 16; L++) begin
      logic [7:0] pc;
      pc = {L[3:0], 4'b0010};
      lock_cycles = L[3:0];
      write_pll({L[0], 7'b0});
      enter_pd(pc);
      e0 = core_edges;
      repeat (3) @(negedge clk);
      chk("R2 core edges", core_edges - e0, 0);
      chk("R2 pll_en", int'(pll_en), 0);
      chk("R3 osc_en", int'(osc_en), int'(!L[0]));
      chk("R4 periph_en", int'(periph_en), 0);
      chk("R6 dac/ale/psen", int'({dac_oe, ale, psen}), 0);
      @(negedge clk); port_wr = 1; port_wdata = 8'h3C;
      @(negedge clk); port_wr = 0;
      chk("R5 port held", int'(port_q), 8'hA5);
      @(negedge clk); irq = 1;
      n = 0;
      do begin
        @(posedge clk); n++; #1; irq = 0;
      end while (pd_active && n < 40);
      chk("R10 wake latency", n, L + 2);
      chk("R8 pcon after wake", int'(pcon_q), int'(pc & 8'hFD));
      chk("R8 port after wake", int'(port_q), 8'hA5);
      e0 = core_edges;
      repeat (3) @(negedge clk);
      chk("R10 core clock back", int'(core_edges > e0), 1);
    end

    // R9 / R4: timer wake with oscillator kept
    write_pll(8'h00);
    tic_limit = 4'd5; lock_cycles = 4'd2;
    @(negedge clk); tic_en = 1;
    enter_pd(8'h02);
    chk("R4 tic_run kept", int'(tic_run), 1);
    wait_awake(60, n);
    chk("R9 timer wake", int'(pd_active), 0);

    // R9 / R4: oscillator stopped, timer cannot wake
    write_pll(8'h80);
    enter_pd(8'h02);
    chk("R4 tic_run stopped", int'(tic_run), 0);
    chk("R3 osc stopped", int'(osc_en), 0);
    repeat (40) @(negedge clk);
    chk("R9 stays asleep", int'(pd_active), 1);

    // R7: reset while asleep
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R7 pd_active", int'(pd_active), 0);
    chk("R7 pcon", int'(pcon_q), 0);
    chk("R7 pllcon", int'(pllcon_q), 0);
    chk("R7 port", int'(port_q), 255);

    // R12: counter period sweep
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); tic_en = 0; tic_limit = k[3:0];
      @(negedge clk); tic_en = 1;
      n = 0;
      do begin @(posedge clk); n++; #1; end while (!tic_irq && n < 40);
      n = 0;
      do begin @(posedge clk); n++; #1; end while (!tic_irq && n < 40);
      chk("R12 tic period", n, k + 1);
    end

    chk("R10 short core pulses", short_pulses, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule